// File: doc/BRIEF.md
# Floating-Point Load Format Converter

This block sits after the data return path of a floating-point load unit. It receives one raw memory word per transfer, with a tag that names how the word is to be read: single precision, double precision, double-extended precision, 64-bit integer, or a raw register image restored from a save area. It produces the 82-bit register value that the register file stores. That value has a sign bit, a 17-bit exponent biased by 65535 and a 64-bit significand whose top bit is an explicit integer bit.

Every finite source exponent is moved into the single wide 17-bit range. Source denormals are not normalised. Each instead receives the fixed exponent that matches its source format's minimum, with the integer bit cleared. Integers sit under a fixed canonical exponent. A separate flag marks a load whose speculation failed. That flag overrides the tag and produces the special not-a-value register encoding.

Transfers use a valid/ready handshake on both sides. There is one register stage, so a result appears one cycle after it is accepted. The result is held while the consumer stalls.

Top module: `fp_load_cvt`

## Requirements
- R1: Tag 0 (single) reads sign at bit 31, exponent at 30:23 and fraction at 22:0. A normal value gives exponent e+0x0FF80, integer bit 1, and the fraction in significand bits 62:40 with zeros below.
- R2: Tag 1 (double) reads sign at bit 63, exponent at 62:52 and fraction at 51:0. A normal value gives exponent e+0x0FC00, integer bit 1, and the fraction in bits 62:11 with zeros below.
- R3: A single or double with an all-ones exponent (infinity or NaN) gives exponent 0x1FFFF, integer bit 1, and its fraction and sign copied.
- R4: A single or double zero gives exponent 0 and significand 0, and keeps its sign.
- R5: A single denormal gives exponent 0x0FF81 and a double denormal gives exponent 0x0FC01. Both have integer bit 0, with the fraction placed as for a normal.
- R6: Tag 2 (double-extended) reads sign at bit 79, exponent at 78:64 and significand at 63:0. The significand is copied, including its integer bit. An all-ones exponent gives 0x1FFFF, an all-zero exponent gives 0, and any other exponent gives e+0x0C000.
- R7: Tag 3 (integer) gives significand = bits 63:0, exponent 0x1003E and sign 0.
- R8: Tag 4 (fill) copies bits 81:0 to the register unchanged. Bits 127:82 have no effect.
- R9: When in_nat is 1, the output is sign 0, exponent 0x1FFFE and significand 0, whatever the tag. Tags 5 to 7 give the same word.
- R10: A word accepted at a clock edge appears on out_word with out_valid high right after that edge. out_valid falls after a transfer if no new word is accepted.
- R11: While out_valid is high and out_ready is low, out_valid and out_word stay unchanged. in_ready equals (not out_valid) or out_ready.
- R12: In reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Load word offered |
| in_ready | output | 1 | Converter can take a word |
| in_fmt | input | 3 | Format tag: 0 single, 1 double, 2 double-extended, 3 integer, 4 fill |
| in_data | input | 128 | Raw memory word, right-aligned |
| in_nat | input | 1 | Failed speculative load, forces the not-a-value encoding |
| out_valid | output | 1 | Register value available |
| out_ready | input | 1 | Consumer takes the value |
| out_word | output | 82 | Register value {sign, exponent[16:0], significand[63:0]} |

## Verification
Every converted value is due on out_word exactly one rising edge after the edge that accepts it. It then stays there for each further edge at which out_ready is low. The bench drives inputs on falling edges and judges acceptance from in_ready at that falling edge. It pushes the value it expects for that word when the next rising edge will take it, and compares the oldest entry at each falling edge where out_valid and out_ready are both high. While the consumer stalls, the bench checks at each falling edge that the held word has not moved. A directed test with out_ready tied high measures the one-cycle latency itself and the drop of out_valid one cycle later.

// File: rtl/fpl_pkg.sv
package fpl_pkg;

  localparam int SIG_W     = 64;
  localparam int EXP_W     = 17;
  localparam int REG_W     = 1 + EXP_W + SIG_W;
  localparam int MEM_W     = 128;
  localparam int TAG_W     = 3;

  localparam logic [EXP_W-1:0] EXP_ONES   = '1;
  localparam logic [EXP_W-1:0] EXP_NAT    = 17'h1FFFE;
  localparam logic [EXP_W-1:0] EXP_INT    = 17'h1003E;
  localparam int               WIDE_BIAS  = 65535;

  localparam int XW_EXP_W  = 15;
  localparam int XW_BIAS   = 16383;

  typedef enum logic [TAG_W-1:0] {
    TAG_SGL  = 3'd0,
    TAG_DBL  = 3'd1,
    TAG_XTD  = 3'd2,
    TAG_INT  = 3'd3,
    TAG_FILL = 3'd4
  } ld_tag_e;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
  } fpreg_t;

endpackage

// File: rtl/fpl_ieee_unpack.sv
module fpl_ieee_unpack
  import fpl_pkg::*;
#(
  parameter int E_W = 8,
  parameter int F_W = 23
) (
  input  logic [E_W+F_W:0] mem_i,
  output fpreg_t           reg_o
);

  localparam int               SRC_BIAS = (1 << (E_W - 1)) - 1;
  localparam logic [EXP_W-1:0] REBIAS   = EXP_W'(WIDE_BIAS - SRC_BIAS);
  localparam logic [EXP_W-1:0] DEN_EXP  = EXP_W'(WIDE_BIAS - SRC_BIAS + 1);
  localparam int               PAD_W    = SIG_W - 1 - F_W;

  logic           s;
  logic [E_W-1:0] e;
  logic [F_W-1:0] f;
  logic           e_ones;
  logic           e_zero;
  logic           f_zero;

  assign s      = mem_i[E_W+F_W];
  assign e      = mem_i[E_W+F_W-1:F_W];
  assign f      = mem_i[F_W-1:0];
  assign e_ones = &e;
  assign e_zero = ~|e;
  assign f_zero = ~|f;

  always_comb begin
    reg_o.sign = s;
    if (e_ones) begin
      reg_o.exp = EXP_ONES;
      reg_o.sig = {1'b1, f, {PAD_W{1'b0}}};
    end else if (e_zero && f_zero) begin
      reg_o.exp = '0;
      reg_o.sig = '0;
    end else if (e_zero) begin
      reg_o.exp = DEN_EXP;
      reg_o.sig = {1'b0, f, {PAD_W{1'b0}}};
    end else begin
      reg_o.exp = EXP_W'(e) + REBIAS;
      reg_o.sig = {1'b1, f, {PAD_W{1'b0}}};
    end
  end

endmodule

// File: rtl/fpl_xtd_unpack.sv
module fpl_xtd_unpack
  import fpl_pkg::*;
(
  input  logic [XW_EXP_W+SIG_W:0] mem_i,
  output fpreg_t                  reg_o
);

  localparam logic [EXP_W-1:0] REBIAS = EXP_W'(WIDE_BIAS - XW_BIAS);

  logic [XW_EXP_W-1:0] e;

  assign e = mem_i[XW_EXP_W+SIG_W-1:SIG_W];

  always_comb begin
    reg_o.sign = mem_i[XW_EXP_W+SIG_W];
    reg_o.sig  = mem_i[SIG_W-1:0];
    if (&e)       reg_o.exp = EXP_ONES;
    else if (~|e) reg_o.exp = '0;
    else          reg_o.exp = EXP_W'(e) + REBIAS;
  end

endmodule

// File: rtl/fpl_out_stage.sv
module fpl_out_stage
  import fpl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_valid,
  output logic   load_ready,
  input  fpreg_t load_word,
  output logic   hold_valid,
  input  logic   hold_ready,
  output fpreg_t hold_word
);

  logic   valid_q, valid_d;
  fpreg_t word_q;
  logic   accept;

  assign load_ready = !valid_q || hold_ready;
  assign accept     = load_valid && load_ready;

  always_comb begin
    if (accept)          valid_d = 1'b1;
    else if (hold_ready) valid_d = 1'b0;
    else                 valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (accept) word_q <= load_word;
  end

  assign hold_valid = valid_q;
  assign hold_word  = word_q;

endmodule

// File: rtl/fp_load_cvt.sv
module fp_load_cvt
  import fpl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [TAG_W-1:0]   in_fmt,
  input  logic [MEM_W-1:0]   in_data,
  input  logic               in_nat,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [REG_W-1:0]   out_word
);

  localparam int SGL_W = 32;
  localparam int DBL_W = 64;
  localparam int XTD_W = 1 + XW_EXP_W + SIG_W;

  fpreg_t sgl_reg, dbl_reg, xtd_reg, cvt_reg, held;
  logic   unused_hi;

  assign unused_hi = ^in_data[MEM_W-1:REG_W];

  fpl_ieee_unpack #(.E_W(8), .F_W(23)) u_sgl (
    .mem_i (in_data[SGL_W-1:0]),
    .reg_o (sgl_reg)
  );

  fpl_ieee_unpack #(.E_W(11), .F_W(52)) u_dbl (
    .mem_i (in_data[DBL_W-1:0]),
    .reg_o (dbl_reg)
  );

  fpl_xtd_unpack u_xtd (
    .mem_i (in_data[XTD_W-1:0]),
    .reg_o (xtd_reg)
  );

  always_comb begin
    cvt_reg = '{sign: 1'b0, exp: EXP_NAT, sig: '0};
    if (!in_nat) begin
      case (in_fmt)
        TAG_SGL:  cvt_reg = sgl_reg;
        TAG_DBL:  cvt_reg = dbl_reg;
        TAG_XTD:  cvt_reg = xtd_reg;
        TAG_INT:  cvt_reg = '{sign: 1'b0, exp: EXP_INT, sig: in_data[SIG_W-1:0]};
        TAG_FILL: cvt_reg = fpreg_t'(in_data[REG_W-1:0]);
        default:  cvt_reg = '{sign: 1'b0, exp: EXP_NAT, sig: '0};
      endcase
    end
  end

  fpl_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (in_valid),
    .load_ready (in_ready),
    .load_word  (cvt_reg),
    .hold_valid (out_valid),
    .hold_ready (out_ready),
    .hold_word  (held)
  );

  assign out_word = held;

endmodule

// File: rtl/fp_load_cvt_chk.sv
module fp_load_cvt_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [2:0]   in_fmt,
  input logic [127:0] in_data,
  input logic         in_nat,
  input logic         out_valid,
  input logic         out_ready,
  input logic [81:0]  out_word
);

  logic fire;
  assign fire = in_valid && in_ready;

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  assert_nat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_nat) |=> (out_word == {1'b0, 17'h1FFFE, 64'h0}));

  assert_int_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_nat && in_fmt == 3'd3) |=>
      (out_word == {1'b0, 17'h1003E, $past(in_data[63:0])}));

  assert_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_nat && in_fmt == 3'd4) |=> (out_word == $past(in_data[81:0])));

  assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_nat && in_fmt == 3'd0 && in_data[30:0] == 31'h0) |=>
      (out_word == {$past(in_data[31]), 81'h0}));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !fire) |=> !out_valid);

endmodule

bind fp_load_cvt fp_load_cvt_chk u_chk (.*);

// File: tb/fp_load_cvt_bench.sv
`timescale 1ns/1ps
module fp_load_cvt_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [2:0]   in_fmt;
  logic [127:0] in_data;
  logic         in_nat;
  logic         out_valid;
  logic         out_ready;
  logic [81:0]  out_word;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit mon_on = 0;
  bit rdy_rand = 0;

  logic [81:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  fp_load_cvt u_fp_load_cvt (.*);

  task automatic check(input bit ok, input string tag, input logic [81:0] act,
                       input logic [81:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [81:0] model(input logic [2:0] f, input logic [127:0] d,
                                        input logic nat);
    logic s;
    if (nat || f > 3'd4) return {1'b0, 17'h1FFFE, 64'h0};
    case (f)
      3'd0: begin
        s = d[31];
        if (d[30:23] == 8'hFF) return {s, 17'h1FFFF, 1'b1, d[22:0], 40'h0};
        if (d[30:0] == 0)      return {s, 81'h0};
        if (d[30:23] == 8'h00) return {s, 17'h0FF81, 1'b0, d[22:0], 40'h0};
        return {s, 17'h0FF80 + {9'h0, d[30:23]}, 1'b1, d[22:0], 40'h0};
      end
      3'd1: begin
        s = d[63];
        if (d[62:52] == 11'h7FF) return {s, 17'h1FFFF, 1'b1, d[51:0], 11'h0};
        if (d[62:0] == 0)        return {s, 81'h0};
        if (d[62:52] == 11'h0)   return {s, 17'h0FC01, 1'b0, d[51:0], 11'h0};
        return {s, 17'h0FC00 + {6'h0, d[62:52]}, 1'b1, d[51:0], 11'h0};
      end
      3'd2: begin
        if (d[78:64] == 15'h7FFF) return {d[79], 17'h1FFFF, d[63:0]};
        if (d[78:64] == 15'h0)    return {d[79], 17'h0, d[63:0]};
        return {d[79], 17'h0C000 + {2'h0, d[78:64]}, d[63:0]};
      end
      3'd3:    return {1'b0, 17'h1003E, d[63:0]};
      default: return d[81:0];
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] f, input logic [127:0] d,
                                   input logic nat);
    if (nat || f > 3'd4) return "R9";
    if (f == 3'd0) begin
      if (d[30:23] == 8'hFF) return "R3";
      if (d[30:0] == 0) return "R4";
      if (d[30:23] == 8'h00) return "R5";
      return "R1";
    end
    if (f == 3'd1) begin
      if (d[62:52] == 11'h7FF) return "R3";
      if (d[62:0] == 0) return "R4";
      if (d[62:52] == 11'h0) return "R5";
      return "R2";
    end
    if (f == 3'd2) return "R6";
    if (f == 3'd3) return "R7";
    return "R8";
  endfunction

  task automatic drive_item(input logic [2:0] f, input logic [127:0] d, input logic nat);
    @(negedge clk);
    in_valid = 1'b1;
    in_fmt   = f;
    in_data  = d;
    in_nat   = nat;
    forever begin
      if (in_ready) begin
        exp_q.push_back(model(f, d, nat));
        tag_q.push_back(tag_of(f, d, nat));
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  // consumer ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    #2;
    if (rdy_rand) out_ready = ($urandom % 3) != 0;
  end

  // scoreboard monitor
  logic [81:0] held_word;
  bit          hold_pend = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (hold_pend)
        check(out_valid && out_word == held_word, "R11 hold", out_word, held_word);
      check(in_ready == (!out_valid || out_ready), "R11 ready",
            {81'h0, in_ready}, {81'h0, (!out_valid || out_ready)});
      hold_pend = out_valid && !out_ready;
      held_word = out_word;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected output", out_word, 82'h0);
        end else begin
          logic [81:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_word == e, t, out_word, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_fmt = 3'd0;
    in_data = '0;
    in_nat = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R12 reset state", {80'h0, out_valid, in_ready}, 82'h1);
    rst_n = 1'b1;

    // directed latency: single 1.0
    @(negedge clk);
    in_valid = 1'b1;
    in_fmt = 3'd0;
    in_data = 128'h3F80_0000;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_word == {1'b0, 17'h0FFFF, 64'h8000_0000_0000_0000},
          "R10 R1 one-cycle result", out_word, {1'b0, 17'h0FFFF, 64'h8000_0000_0000_0000});
    @(negedge clk);
    check(!out_valid, "R10 valid drops", {81'h0, out_valid}, 82'h0);

    mon_on = 1;
    rdy_rand = 1;
    // directed corner values
    drive_item(3'd0, 128'hFF80_0000, 0);                 // -inf single R3
    drive_item(3'd0, 128'h7FC0_0001, 0);                 // NaN single R3
    drive_item(3'd0, 128'h8000_0000, 0);                 // -0 single R4
    drive_item(3'd0, 128'h0000_0001, 0);                 // min denormal R5
    drive_item(3'd1, 128'h3FF0_0000_0000_0000, 0);       // 1.0 double R2
    drive_item(3'd1, 128'h8000_0000_0000_0000, 0);       // -0 double R4
    drive_item(3'd1, 128'h000F_FFFF_FFFF_FFFF, 0);       // max denormal R5
    drive_item(3'd1, 128'h7FF0_0000_0000_0000, 0);       // +inf double R3
    drive_item(3'd2, {48'h0, 16'hBFFF, 64'h8000_0000_0000_0000}, 0); // R6
    drive_item(3'd2, {48'h0, 16'h7FFF, 64'hC000_0000_0000_0000}, 0); // R6 ones
    drive_item(3'd2, {48'h0, 16'h0000, 64'h8000_0000_0000_0001}, 0); // R6 pseudo-denormal
    drive_item(3'd3, 128'hFFFF_FFFF_FFFF_FFFF, 0);       // R7
    drive_item(3'd4, {46'h3FFF_FFFF_FFFF, 82'h2_AAAA_5555_1234_5678_9ABC}, 0); // R8 upper ignored
    drive_item(3'd1, 128'h3FF0_0000_0000_0000, 1);       // R9 nat
    drive_item(3'd6, 128'h1234, 0);                      // R9 reserved tag

    for (int i = 0; i < 300; i++) begin
      logic [127:0] d;
      logic [2:0]   f;
      int           k;
      d = {$urandom, $urandom, $urandom, $urandom};
      f = 3'($urandom % 8);
      k = $urandom % 4;
      if (f == 3'd0 && k == 0) d[30:23] = 8'h00;
      if (f == 3'd0 && k == 1) d[30:23] = 8'hFF;
      if (f == 3'd1 && k == 0) d[62:52] = 11'h0;
      if (f == 3'd1 && k == 1) d[62:52] = 11'h7FF;
      if (f == 3'd2 && k == 0) d[78:64] = 15'h0;
      if (f == 3'd2 && k == 1) d[78:64] = 15'h7FFF;
      drive_item(f, d, ($urandom % 8) == 0);
    end

    @(negedge clk);
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule